// File: doc/BRIEF.md
# Predicated Replicating Quadword Vector Load

This block performs a masked load of one 128-bit quadword built from eight 16-bit elements and spreads that quadword over a vector whose width is set by a parameter. A start pulse brings a 64-bit base, a 64-bit index and a governing predicate. The effective address is the base plus twice the index, so the index counts whole halfwords. Lane k of the quadword reads the halfword at the effective address plus 2*k.

Each active lane issues one halfword read on a simple request/response memory port. Requests go out in ascending lane order, and only one request is outstanding at a time. Inactive lanes issue no request, cannot fault and take the value zero. When every active lane has returned, the block copies the assembled quadword into every 128-bit slice of the result and pulses done.

A faulting response ends the operation early. The block then pulses done with the fault flag set and leaves the result register as it was.

Top module: `qrv_vload`

## Requirements
- R1: For lane k the request address is base_i + (index_i << 1) + 2*k, computed modulo 2^64. base_i and index_i are sampled with start_i.
- R2: A request is issued only for a lane k whose predicate bit pred_i[2*k] is set. Requests go out in ascending k. req_valid_o stays low from an accepted request until its response arrives.
- R3: In the result, lane k of the quadword occupies bits [16*k+15:16*k]. It holds the returned halfword when the lane is active and zero when it is not.
- R4: On a successful completion every 128-bit slice of vec_o equals the assembled quadword. Odd predicate bits and all predicate bits at index 16 and above have no effect.
- R5: A response with rsp_fault_i high stops any further requests. The cycle after that response, done_o and fault_o rise together and vec_o keeps its previous value. A fault address that belongs only to an inactive lane never faults.
- R6: With no active lane, done_o rises after the second rising clock edge counting from the edge that samples start_i. No request is issued, fault_o is low and vec_o is all zero.
- R7: start_i is ignored while an operation is in progress, and the inputs presented with it have no effect.
- R8: done_o is high for exactly one cycle per operation. Between done pulses vec_o does not change. fault_o holds its value until the next accepted start.
- R9: While rst_n is low and after it is released, req_valid_o, done_o and fault_o are low and vec_o is zero until the first completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (ignored while busy) |
| base_i | input | 64 | Base byte address |
| index_i | input | 64 | Halfword index, scaled by two |
| pred_i | input | VLEN_BITS/8 | Governing predicate, one bit per vector byte; lane k uses bit 2*k |
| req_valid_o | output | 1 | Halfword read request, accepted in the same cycle |
| req_addr_o | output | 64 | Byte address of the read |
| rsp_valid_i | input | 1 | Response for the outstanding request |
| rsp_data_i | input | 16 | Returned halfword |
| rsp_fault_i | input | 1 | The read faulted |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Operation ended on a fault |
| vec_o | output | VLEN_BITS | Replicated result vector |

## Verification
The bench builds the block with VLEN_BITS = 2048, the widest supported vector. Replication is therefore checked across sixteen slices, and 240 predicate bits above the quadword are driven with junk that must have no effect. The memory model answers with a latency set per operation of one to three cycles. This covers back-to-back request/response timing as well as the long waits during which stray start pulses must be ignored.

// File: rtl/qrv_pkg.sv
// Package: shared constants and state type for the replicating quadword load.
// Assumes a fixed 128-bit segment of 16-bit elements; only the vector width varies.
package qrv_pkg;
    localparam int ELEM_W     = 16;
    localparam int SEG_W      = 128;
    localparam int LANES      = SEG_W / ELEM_W;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int ADDR_W     = 64;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } qrv_state_e;
endpackage

// File: rtl/qrv_lane_pick.sv
// Module: picks the lowest-numbered lane still pending.
// Assumes the pending mask is one bit per segment lane; lane is don't-care when none is set.
module qrv_lane_pick
    import qrv_pkg::*;
(
    input  logic [LANES-1:0]      pend_i,
    output logic [LANE_IDX_W-1:0] lane_o,
    output logic                  any_o
);
    // Priority search from the top, so the lowest set bit wins.
    always_comb begin
        lane_o = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                lane_o = LANE_IDX_W'(i);
            end
        end
    end

    // Flags that at least one lane remains.
    assign any_o = |pend_i;
endmodule

// File: rtl/qrv_addr_gen.sv
// Module: holds the scaled effective address and forms each lane's byte address.
// Assumes the address wraps modulo 2^64 and the element is two bytes.
module qrv_addr_gen
    import qrv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [ADDR_W-1:0]     index_i,
    input  logic [LANE_IDX_W-1:0] lane_i,
    output logic [ADDR_W-1:0]     addr_o
);
    logic [ADDR_W-1:0] eff_q;

    // Latches base plus index scaled by the halfword size at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_q <= '0;
        end else if (capture_i) begin
            eff_q <= base_i + (index_i << 1);
        end
    end

    // Adds the lane's byte offset, two bytes per lane.
    assign addr_o = eff_q + ADDR_W'({lane_i, 1'b0});
endmodule

// File: rtl/qrv_seg_buf.sv
// Module: eight halfword registers that assemble the quadword.
// Assumes clear and write never target the same cycle; clear wins if they do.
module qrv_seg_buf
    import qrv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  wr_en_i,
    input  logic [LANE_IDX_W-1:0] wr_lane_i,
    input  logic [ELEM_W-1:0]     wr_data_i,
    output logic [SEG_W-1:0]      seg_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ELEM_W-1:0] elem_q;

        // Zeroes the lane at start, loads it when its response returns.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                elem_q <= '0;
            end else if (wr_en_i && (wr_lane_i == LANE_IDX_W'(g))) begin
                elem_q <= wr_data_i;
            end
        end

        assign seg_o[g*ELEM_W +: ELEM_W] = elem_q;
    end
endmodule

// File: rtl/qrv_replicate.sv
// Module: copies one 128-bit segment into every segment of the vector.
// Assumes VLEN_BITS is a whole multiple of 128.
module qrv_replicate
    import qrv_pkg::*;
#(
    parameter int VLEN_BITS = 512
) (
    input  logic [SEG_W-1:0]     seg_i,
    output logic [VLEN_BITS-1:0] vec_o
);
    localparam int NSEG = VLEN_BITS / SEG_W;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign vec_o[s*SEG_W +: SEG_W] = seg_i;
    end
endmodule

// File: rtl/qrv_vload.sv
// Module: predicated halfword quadword load with replication across the vector.
// Lane k uses predicate bit 2*k. Active lanes read one at a time in ascending
// order; a fault ends the operation and leaves the result register untouched.
// Assumes VLEN_BITS is a multiple of 128 and the memory accepts a request at once.
module qrv_vload
    import qrv_pkg::*;
#(
    parameter int VLEN_BITS = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [ADDR_W-1:0]      base_i,
    input  logic [ADDR_W-1:0]      index_i,
    input  logic [VLEN_BITS/8-1:0] pred_i,
    output logic                   req_valid_o,
    output logic [ADDR_W-1:0]      req_addr_o,
    input  logic                   rsp_valid_i,
    input  logic [ELEM_W-1:0]      rsp_data_i,
    input  logic                   rsp_fault_i,
    output logic                   done_o,
    output logic                   fault_o,
    output logic [VLEN_BITS-1:0]   vec_o
);
    localparam int PRED_W = VLEN_BITS / 8;

    qrv_state_e              state_q;
    logic [LANES-1:0]        act_mask;
    logic [LANES-1:0]        pend_q;
    logic [LANE_IDX_W-1:0]   cur_lane_q;
    logic [LANE_IDX_W-1:0]   next_lane;
    logic                    any_pend;
    logic                    accept;
    logic                    rsp_ok;
    logic [SEG_W-1:0]        seg;
    logic [VLEN_BITS-1:0]    rep_vec;
    logic                    done_q;
    logic                    fault_q;
    logic [VLEN_BITS-1:0]    vec_q;

    // Takes the even predicate bit of each halfword lane in the low segment.
    for (genvar k = 0; k < LANES; k++) begin : g_mask
        assign act_mask[k] = (2*k < PRED_W) ? pred_i[2*k] : 1'b0;
    end

    assign accept = (state_q == ST_IDLE) && start_i;
    assign rsp_ok = (state_q == ST_WAIT) && rsp_valid_i && !rsp_fault_i;

    qrv_lane_pick u_pick (
        .pend_i (pend_q),
        .lane_o (next_lane),
        .any_o  (any_pend)
    );

    qrv_addr_gen u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (accept),
        .base_i    (base_i),
        .index_i   (index_i),
        .lane_i    (next_lane),
        .addr_o    (req_addr_o)
    );

    qrv_seg_buf u_seg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .wr_en_i   (rsp_ok),
        .wr_lane_i (cur_lane_q),
        .wr_data_i (rsp_data_i),
        .seg_o     (seg)
    );

    qrv_replicate #(.VLEN_BITS(VLEN_BITS)) u_rep (
        .seg_i (seg),
        .vec_o (rep_vec)
    );

    // Sequences start, per-lane issue and wait, and completion or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_q     <= '0;
            cur_lane_q <= '0;
            done_q     <= 1'b0;
            fault_q    <= 1'b0;
            vec_q      <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        pend_q  <= act_mask;
                        fault_q <= 1'b0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (any_pend) begin
                        cur_lane_q <= next_lane;
                        state_q    <= ST_WAIT;
                    end else begin
                        done_q  <= 1'b1;
                        vec_q   <= rep_vec;
                        state_q <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid_i) begin
                        if (rsp_fault_i) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            pend_q[cur_lane_q] <= 1'b0;
                            state_q            <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drives a request whenever a lane is ready to go out.
    assign req_valid_o = (state_q == ST_ISSUE) && any_pend;
    assign done_o      = done_q;
    assign fault_o     = fault_q;
    assign vec_o       = vec_q;
endmodule

// File: rtl/qrv_vload_chk.sv
// Module: protocol checker for qrv_vload, attached by bind below.
// Assumes the memory returns exactly one response per accepted request.
module qrv_vload_chk
    import qrv_pkg::*;
#(
    parameter int VLEN_BITS = 512
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid_o,
    input logic                 rsp_valid_i,
    input logic                 rsp_fault_i,
    input logic                 done_o,
    input logic                 fault_o,
    input logic [VLEN_BITS-1:0] vec_o
);
    localparam int NSEG = VLEN_BITS / SEG_W;

    logic outstanding_q;

    // Tracks whether a request is waiting for its response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
        end else if (req_valid_o) begin
            outstanding_q <= 1'b1;
        end else if (rsp_valid_i) begin
            outstanding_q <= 1'b0;
        end
    end

    function automatic logic slices_match(input logic [VLEN_BITS-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int s = 1; s < NSEG; s++) begin
            if (v[s*SEG_W +: SEG_W] != v[SEG_W-1:0]) ok = 1'b0;
        end
        return ok;
    endfunction

    a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding_q |-> !req_valid_o);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r4_slices_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> slices_match(vec_o));

    a_r5_fault_keeps_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> $stable(vec_o));

    a_r5_fault_from_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> $past(rsp_valid_i && rsp_fault_i));

    a_r8_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(vec_o));

    a_r5_no_req_at_fault_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> !req_valid_o);
endmodule

bind qrv_vload qrv_vload_chk #(.VLEN_BITS(VLEN_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_o (req_valid_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_fault_i (rsp_fault_i),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .vec_o       (vec_o)
);

// File: tb/qrv_vload_tb_top.sv
// Bench: behavioural memory and reference model for qrv_vload, compared every clock.
module qrv_vload_tb_top;
    localparam int VL   = 2048;
    localparam int PW   = VL / 8;
    localparam int NSEG = VL / 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [63:0]   base_i = '0;
    logic [63:0]   index_i = '0;
    logic [PW-1:0] pred_i = '0;
    logic          req_valid_o;
    logic [63:0]   req_addr_o;
    logic          rsp_valid_i;
    logic [15:0]   rsp_data_i;
    logic          rsp_fault_i;
    logic          done_o;
    logic          fault_o;
    logic [VL-1:0] vec_o;

    qrv_vload #(.VLEN_BITS(VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .index_i(index_i), .pred_i(pred_i), .req_valid_o(req_valid_o),
        .req_addr_o(req_addr_o), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
        .rsp_fault_i(rsp_fault_i), .done_o(done_o), .fault_o(fault_o), .vec_o(vec_o)
    );

    always #2 clk = ~clk;

    int            checks = 0;
    int            errors = 0;
    int            cyc = 0;
    logic [VL-1:0] model_vec = '0;
    logic [VL-1:0] exp_vec = '0;
    bit            exp_fault = 1'b0;
    logic [63:0]   exp_q[$];
    bit            op_active = 1'b0;
    bit            zero_chk = 1'b0;
    int            start_cyc = 0;
    int            lat = 1;
    bit            fault_on = 1'b0;
    logic [63:0]   fault_at = '0;
    int            cd = 0;
    logic [63:0]   raddr = '0;
    bit            prev_done = 1'b0;
    bit            finished = 1'b0;

    function automatic logic [15:0] mem_word(input logic [63:0] a);
        return a[15:0] ^ {a[7:0], a[15:8]} ^ a[31:16] ^ 16'hC3A5;
    endfunction

    task automatic chk(input bit ok, input string msg,
                       input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
            summary();
        end
    end

    // Memory responder and per-clock comparison against the model.
    always @(negedge clk) begin
        bit was_out;
        if (!rst_n) begin
            rsp_valid_i = 1'b0;
            rsp_data_i  = '0;
            rsp_fault_i = 1'b0;
            cd = 0;
            prev_done = 1'b0;
        end else begin
            was_out = (cd != 0);
            rsp_valid_i = 1'b0;
            rsp_fault_i = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    rsp_valid_i = 1'b1;
                    rsp_data_i  = mem_word(raddr);
                    rsp_fault_i = fault_on && (raddr == fault_at);
                end
            end
            if (req_valid_o) begin
                chk(!was_out, "R2 request while one outstanding", VL'(req_valid_o), '0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected request", VL'(req_addr_o), '0);
                end else begin
                    logic [63:0] a;
                    a = exp_q.pop_front();
                    chk(req_addr_o == a, "R1 request address/order", VL'(req_addr_o), VL'(a));
                end
                raddr = req_addr_o;
                cd = lat;
            end
            if (done_o) begin
                chk(!prev_done, "R8 done longer than one cycle", 1, 0);
                chk(op_active, "R8 done without operation", 1, 0);
                chk(exp_q.size() == 0, "R2 missing requests", VL'(exp_q.size()), 0);
                chk(fault_o == exp_fault, "R5 fault flag", VL'(fault_o), VL'(exp_fault));
                if (exp_fault) begin
                    chk(vec_o == model_vec, "R5 vector kept on fault", vec_o, model_vec);
                end else begin
                    chk(vec_o == exp_vec, "R3 R4 result vector", vec_o, exp_vec);
                    model_vec = exp_vec;
                end
                if (zero_chk) begin
                    chk(cyc - start_cyc == 2, "R6 no-lane latency", VL'(cyc - start_cyc), 2);
                end
                op_active = 1'b0;
            end else begin
                chk(vec_o == model_vec, "R8 vector stable between done", vec_o, model_vec);
            end
            prev_done = done_o;
        end
    end

    task automatic run_op(input logic [63:0] b, input logic [63:0] idx,
                          input logic [PW-1:0] p, input int latency,
                          input bit f_en, input logic [63:0] f_addr,
                          input bit stray, input bit zchk);
        logic [63:0]  eff;
        logic [127:0] seg;
        int           wait_n;
        @(negedge clk);
        start_i = 1'b1; base_i = b; index_i = idx; pred_i = p;
        eff = b + (idx << 1);
        seg = '0;
        exp_q.delete();
        exp_fault = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (p[2*k] && !exp_fault) begin
                logic [63:0] a;
                a = eff + 64'(2*k);
                exp_q.push_back(a);
                if (f_en && a == f_addr) exp_fault = 1'b1;
                else seg[16*k +: 16] = mem_word(a);
            end
        end
        exp_vec = {NSEG{seg}};
        lat = latency; fault_on = f_en; fault_at = f_addr;
        zero_chk = zchk; start_cyc = cyc; op_active = 1'b1;
        @(negedge clk);
        if (stray) begin
            base_i = ~b; index_i = ~idx; pred_i = ~p;
            @(negedge clk);
            @(negedge clk);
        end
        start_i = 1'b0;
        wait_n = 0;
        while (op_active && wait_n < 200) begin
            @(negedge clk);
            wait_n++;
        end
        chk(!op_active, "R8 operation never completed", VL'(wait_n), 0);
        op_active = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!req_valid_o && !done_o && !fault_o, "R9 control outputs in reset",
            VL'({req_valid_o, done_o, fault_o}), 0);
        chk(vec_o == '0, "R9 vector in reset", vec_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid_o && !done_o && vec_o == '0, "R9 idle after reset", VL'(req_valid_o), 0);

        // R1 R3 R4: all lanes, junk in upper and odd predicate bits.
        run_op(64'h0000_1000_0000_0100, 64'h10, {{(PW-16){1'b1}}, 16'hFFFF}, 1, 0, '0, 0, 0);
        // R2 R3: lanes 0,2,4,6 only, latency 2, odd bits set.
        run_op(64'h0000_0000_2000_0000, 64'h7, {{(PW-16){1'b0}}, 16'h3B3B}, 2, 0, '0, 0, 0);
        // R6 R4: only odd bits and upper bits set, so no lane active.
        run_op(64'h1234, 64'h1, {{(PW-16){1'b1}}, 16'hAAAA}, 1, 0, '0, 0, 1);
        // R6: empty predicate.
        run_op(64'h55, 64'h0, '0, 1, 0, '0, 0, 1);
        // R1: address wraps past 2^64, index top bit shifted out.
        run_op(64'hFFFF_FFFF_FFFF_FFF8, 64'h8000_0000_0000_0001,
               {{(PW-16){1'b0}}, 16'h5555}, 1, 0, '0, 0, 0);
        // R5: fault on lane 3 stops after four requests.
        run_op(64'h0000_0000_0000_4000, 64'h0, {{(PW-16){1'b0}}, 16'h5555}, 2, 1,
               64'h4006, 0, 0);
        // R5 R2: fault address belongs to inactive lane 1, never accessed.
        run_op(64'h0000_0000_0000_8000, 64'h0, {{(PW-16){1'b0}}, 16'h5551}, 1, 1,
               64'h8002, 0, 0);
        // R7: stray start pulses with different inputs while busy.
        run_op(64'h0000_0000_0000_C001, 64'h3, {{(PW-16){1'b0}}, 16'h0411}, 3, 0, '0, 1, 0);
        // R8: a fault leaves fault_o high until the next start.
        run_op(64'h9000, 64'h0, {{(PW-16){1'b0}}, 16'h0001}, 1, 1, 64'h9000, 0, 0);
        repeat (3) @(negedge clk);
        chk(fault_o == 1'b1, "R8 fault flag held", VL'(fault_o), 1);
        run_op(64'hA000, 64'h2, {{(PW-16){1'b0}}, 16'h4004}, 1, 0, '0, 0, 0);
        chk(fault_o == 1'b0, "R8 fault flag cleared by new start", VL'(fault_o), 0);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule